// File: doc/BRIEF.md
# Two-Length Pseudo-Random Noise Generator

This block produces a one-bit pseudo-random noise stream for a sound channel. The source is a 15-bit register that shifts right and takes its feedback from an XOR of two of its own bits. A one-bit length select picks which second bit feeds the XOR. One setting gives a maximal sequence of 32767 steps, with a hiss-like character. The other gives a 93-step sequence, with a metallic, tonal character.

The register moves only in cycles where a step strobe is high. That strobe comes from a period timer outside this block, so the timer sets the pitch of the noise. The output bit is the inverse of the register's lowest bit, which keeps the channel silent while that bit is 1. The full register value is also brought out for observation.

Reset is asynchronous and active low, and its release is synchronised inside the block. Reset loads a seed of 1, because an all-zero register would never leave zero.

Top module: `noise_lfsr_gen`

## Requirements
- R1: While reset is asserted, and after reset until the first step, `lfsr_state_o` is 15'h0001 and `noise_o` is 0. Reset takes effect without waiting for a clock edge.
- R2: In every cycle, `noise_o` equals the inverse of `lfsr_state_o[0]`.
- R3: In a cycle where `step_en_i` is 0, `lfsr_state_o` keeps its value, whatever `len_sel_i` does.
- R4: With `len_sel_i` = 0 (long), an enabled step sets the new state to {s[0]^s[1], s[14:1]}, where s is the state before the step.
- R5: With `len_sel_i` = 1 (short), an enabled step sets the new state to {s[0]^s[6], s[14:1]}.
- R6: Starting from the seed in long mode, the state first returns to 15'h0001 after exactly 32767 enabled steps.
- R7: Starting from the seed in short mode, the state first returns to 15'h0001 after exactly 93 enabled steps.
- R8: Changing `len_sel_i` does not alter the register contents. The new tap is used from the next enabled step onward.
- R9: After reset, the state never becomes all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| step_en_i | input | 1 | Step strobe from the external period timer |
| len_sel_i | input | 1 | Sequence length select: 0 long, 1 short |
| noise_o | output | 1 | Noise bit, inverse of state bit 0 |
| lfsr_state_o | output | 15 | Current register value |

## Verification
The generator is stepped in long mode and in short mode. The two tap positions give different bit-14 fills within a few steps, so each mode's feedback is confirmed on its own. Stretches with the strobe held low, combined with toggling of the length select, show that the register holds and that a mode switch leaves the contents alone. A mode switch in the middle of a run shows that the new tap applies from the next step. Full runs from the seed in each mode are counted until the seed returns, and the counts must be 32767 and 93. A wrong tap or a wrong register width changes these counts. A reset in the middle of a run must bring the seed back at once.

// File: rtl/noise_lfsr_pkg.sv
package noise_lfsr_pkg;
  localparam int unsigned LFSR_W    = 15;
  localparam int unsigned LONG_TAP  = 1;
  localparam int unsigned SHORT_TAP = 6;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 15'h0001;

  typedef enum logic {
    SEQ_LONG  = 1'b0,
    SEQ_SHORT = 1'b1
  } seq_len_e;
endpackage

// File: rtl/noise_rst_sync.sv
module noise_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/noise_fb_tap.sv
module noise_fb_tap
  import noise_lfsr_pkg::*;
#(
  parameter int unsigned W       = LFSR_W,
  parameter int unsigned TAP_LNG = LONG_TAP,
  parameter int unsigned TAP_SHT = SHORT_TAP
) (
  input  logic [W-1:0] state_i,
  input  seq_len_e     len_i,
  output logic         fb_o
);
  logic second_bit;

  generate
    if (TAP_LNG == TAP_SHT) begin : g_fixed_tap
      assign second_bit = state_i[TAP_LNG];
    end else begin : g_muxed_tap
      assign second_bit = (len_i == SEQ_SHORT) ? state_i[TAP_SHT] : state_i[TAP_LNG];
    end
  endgenerate

  assign fb_o = state_i[0] ^ second_bit;
endmodule

// File: rtl/noise_shift_reg.sv
module noise_shift_reg
  import noise_lfsr_pkg::*;
#(
  parameter int unsigned      W    = LFSR_W,
  parameter logic [W-1:0]     SEED = LFSR_SEED
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         adv_i,
  input  logic         fb_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_r;
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q_r;
    if (adv_i) q_nxt = {fb_i, q_r[W-1:1]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_r <= SEED;
    else         q_r <= q_nxt;
  end

  assign q_o = q_r;
endmodule

// File: rtl/noise_lfsr_gen.sv
module noise_lfsr_gen
  import noise_lfsr_pkg::*;
#(
  parameter int unsigned           W          = LFSR_W,
  parameter int unsigned           TAP_LNG    = LONG_TAP,
  parameter int unsigned           TAP_SHT    = SHORT_TAP,
  parameter logic [LFSR_W-1:0]     SEED       = LFSR_SEED,
  parameter int unsigned           RST_STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_en_i,
  input  logic         len_sel_i,
  output logic         noise_o,
  output logic [W-1:0] lfsr_state_o
);
  logic         core_rst_n;
  logic         fb;
  logic [W-1:0] state;
  seq_len_e     len_mode;

  assign len_mode = seq_len_e'(len_sel_i);

  noise_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (core_rst_n)
  );

  noise_fb_tap #(.W(W), .TAP_LNG(TAP_LNG), .TAP_SHT(TAP_SHT)) u_tap (
    .state_i (state),
    .len_i   (len_mode),
    .fb_o    (fb)
  );

  noise_shift_reg #(.W(W), .SEED(SEED[W-1:0])) u_sr (
    .clk_i  (clk_i),
    .rst_ni (core_rst_n),
    .adv_i  (step_en_i),
    .fb_i   (fb),
    .q_o    (state)
  );

  assign lfsr_state_o = state;
  assign noise_o      = ~state[0];
endmodule

// File: rtl/noise_lfsr_chk.sv
module noise_lfsr_chk #(
  parameter int unsigned W = 15
) (
  input logic         clk_i,
  input logic         rst_n,
  input logic         step_en_i,
  input logic         len_sel_i,
  input logic [W-1:0] state_i
);
  // R3
  hold_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (rst_n && !step_en_i) |=> $stable(state_i));

  // R4
  long_step_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (rst_n && step_en_i && !len_sel_i) |=>
      (state_i == {$past(state_i[0] ^ state_i[1]), $past(state_i[W-1:1])}));

  // R5
  short_step_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (rst_n && step_en_i && len_sel_i) |=>
      (state_i == {$past(state_i[0] ^ state_i[6]), $past(state_i[W-1:1])}));

  // R9
  never_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    state_i != '0);
endmodule

bind noise_lfsr_gen noise_lfsr_chk #(.W(W)) u_chk (
  .clk_i     (clk_i),
  .rst_n     (core_rst_n),
  .step_en_i (step_en_i),
  .len_sel_i (len_sel_i),
  .state_i   (lfsr_state_o)
);

// File: tb/sim_noise_lfsr_gen.sv
module sim_noise_lfsr_gen;
  localparam int CLK_PERIOD = 10;
  localparam int W = 15;

  typedef struct {
    logic [W-1:0] st;
    string        tag;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         en = 1'b0;
  logic         len = 1'b0;
  logic         noise;
  logic [W-1:0] state;

  int vectors = 0;
  int miscompares = 0;
  logic [W-1:0] model = 15'h0001;
  exp_t sb[$];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  noise_lfsr_gen u0 (
    .clk_i(clk), .rst_ni(rst_n), .step_en_i(en), .len_sel_i(len),
    .noise_o(noise), .lfsr_state_o(state)
  );

  function automatic logic [W-1:0] nxt(logic [W-1:0] s, logic m);
    logic fb;
    fb = s[0] ^ (m ? s[6] : s[1]);
    return {fb, s[W-1:1]};
  endfunction

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops expected items after each rising edge
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check(e.tag, state, e.st);
      check("R2 noise", {14'd0, noise}, {14'd0, ~e.st[0]});
    end
  end

  task automatic drive(logic e_i, logic m_i, string tag);
    exp_t it;
    @(negedge clk);
    en = e_i; len = m_i;
    if (e_i) model = nxt(model, m_i);
    it.st = model; it.tag = tag;
    sb.push_back(it);
    @(posedge clk); #2;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; en = 1'b0;
    #1;
    check("R1 async reset state", state, 15'h0001);
    check("R1 reset noise", {14'd0, noise}, 15'd0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    model = 15'h0001;
    check("R1 state after release", state, 15'h0001);
  endtask

  task automatic measure(logic m_i, int exp_len, string tag);
    int n = 0;
    bit hit = 0;
    while (!hit && n < 40000) begin
      drive(1'b1, m_i, tag);
      n++;
      if (state == 15'h0001) hit = 1;
    end
    check(tag, n[W-1:0], exp_len[W-1:0]);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    #1;
    check("R1 state in reset", state, 15'h0001);
    do_reset();
    // long mode steps
    for (int i = 0; i < 40; i++) drive(1'b1, 1'b0, "R4 long step");
    // idle with mode toggling
    for (int i = 0; i < 6; i++) drive(1'b0, i[0], "R3 hold idle");
    // short mode from nontrivial state
    for (int i = 0; i < 40; i++) drive(1'b1, 1'b1, "R5 short step");
    // mid-run switch: idle change, then next step uses new tap
    drive(1'b0, 1'b0, "R8 switch no disturb");
    drive(1'b0, 1'b1, "R8 switch no disturb");
    for (int i = 0; i < 10; i++) drive(1'b1, i[1], "R8 alternating taps");
    // irregular strobe
    for (int i = 0; i < 30; i++) drive((i % 3) != 0, 1'b0, "R3 R4 gapped strobe");
    do_reset();
    measure(1'b0, 32767, "R6 long period");
    do_reset();
    measure(1'b1, 93, "R7 short period");
    do_reset();
    repeat (3) @(posedge clk);
    #2;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule